// File: doc/BRIEF.md
# Dual Watchdog and Longdog Supervisor

This block watches a host processor with two timers that run side by side from one service input. The shorter timer, the watchdog, pulls an active-low interrupt line when the host stops servicing it. The longer timer, the longdog, pulls an active-low reset line for a programmable pulse width. A rising edge on the service input (`kick_i`) restarts both timers from zero. The same edge also ends a reset pulse early.

All timing is counted in ticks of an external strobe (`tick_i`, nominally one per millisecond). The timeouts and the reset width come from an 8-bit configuration byte. A sticky status flag records that a watchdog timeout reached the interrupt line.

The level held on `kick_i` selects the mode of operation:
- Held low, the timers free-run and produce a repeating train of interrupts and resets.
- Held high, the interrupt path is masked and only the reset path stays active.

Top module: `sup_dual_dog`

## Requirements
- R1: A rising edge on `kick_i` clears both the watchdog and longdog counters in the same clock. It also releases `irq_no`. Both timers then count ticks from zero together.
- R2: `cfg_i[2:0]` selects the watchdog period in ticks: 001=400, 010=800, 011=1600, 100=3200, 101=6400. Codes 000, 110 and 111 turn the watchdog off. With `kick_i` low, `irq_no` goes low in the clock of the tick that completes the period.
- R3: A watchdog expiry with `kick_i` low also sets `wdt_flag_o`. The flag stays set until `rst_ni` is asserted.
- R4: `cfg_i[4:3]` selects the longdog period in ticks: 00=off, 01=1600, 10=3200, 11=6400. `rst_no` goes low in the clock of the tick that completes the period.
- R5: `cfg_i[6:5]` selects the reset pulse width: 00=25, 01=50, 10=100, 11=200 ticks. Without a kick, `rst_no` stays low for exactly that many ticks.
- R6: A rising edge on `kick_i` while `rst_no` is low returns `rst_no` high on the next clock.
- R7: When `rst_no` returns high, both timers restart from zero and `irq_no` is high. If both timers expire on the same tick, the longdog wins and `irq_no` stays high. So a longdog period no longer than the watchdog period never produces an interrupt.
- R8: While `kick_i` is high, a watchdog expiry neither drives `irq_no` low nor sets `wdt_flag_o`. The reset path still works.
- R9: A timer whose code selects off holds at zero, and its output never asserts.
- R10: The counters advance only on clocks where `tick_i` is high.
- R11: `cfg_i[7]` has no effect on the timers or the outputs.
- R12: After `rst_ni` is released, `irq_no` and `rst_no` are high and `wdt_flag_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase strobe, one clock wide per tick |
| kick_i | input | 1 | Service input; a rising edge restarts the timers, and its level selects the mode |
| cfg_i | input | 8 | Configuration byte: [7] unused, [6:5] reset width, [4:3] longdog period, [2:0] watchdog period |
| irq_no | output | 1 | Watchdog interrupt, active low |
| rst_no | output | 1 | Longdog reset, active low |
| wdt_flag_o | output | 1 | Sticky watchdog-timeout status |

## Verification
The bench measures the tick count from a kick to each output edge for every period code. This catches a design that is off by one tick or maps a code to the wrong multiple. It also runs the case where both timers expire on the same tick; a design that favoured the watchdog would pulse `irq_no` before every reset. Further directed runs cover:
- a kick in the middle of a reset pulse, where a design without early release would hold the reset for its full width;
- `kick_i` held high, where a design that failed to mask the interrupt would pull `irq_no` low and set the flag;
- a strobe held low, where a design that counted clocks instead of ticks would expire far too soon.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef struct packed {
    logic       seq;   // not used by this block
    logic [1:0] rto;
    logic [1:0] ld;
    logic [2:0] wd;
  } sup_cfg_t;

  function automatic int unsigned wd_ticks(logic [2:0] code, int unsigned unit);
    case (code)
      3'd1:    return unit;
      3'd2:    return unit * 2;
      3'd3:    return unit * 4;
      3'd4:    return unit * 8;
      3'd5:    return unit * 16;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned ld_ticks(logic [1:0] code, int unsigned unit);
    case (code)
      2'd1:    return unit;
      2'd2:    return unit * 2;
      2'd3:    return unit * 4;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned rto_ticks(logic [1:0] code, int unsigned unit);
    return unit << code;
  endfunction

endpackage

// File: rtl/sup_kick_edge.sv
module sup_kick_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic rise_o
);
  logic kick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kick_q <= 1'b0;
    else         kick_q <= kick_i;
  end

  assign rise_o = kick_i & ~kick_q;

  p_rise_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/sup_tmr.sv
module sup_tmr #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;
  logic         done_q;
  logic         en;
  logic [W:0]   nxt;

  assign en    = (limit_i != '0);
  assign nxt   = {1'b0, cnt_q} + 1'b1;
  assign hit_o = tick_i & en & ~clr_i & ~done_q & (nxt >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (clr_i || !en) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (tick_i && !done_q) begin
      cnt_q <= nxt[W-1:0];
      if (hit_o) done_q <= 1'b1;
    end
  end

  p_off_holds_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> (cnt_q == '0));
  p_no_tick_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i && en) |=> $stable(cnt_q));
  p_single_hit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !clr_i) |=> done_q);

endmodule

// File: rtl/sup_dual_dog.sv
module sup_dual_dog #(
  parameter int unsigned WD_UNIT  = 400,
  parameter int unsigned LD_UNIT  = 1600,
  parameter int unsigned RTO_UNIT = 25
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       kick_i,
  input  logic [7:0] cfg_i,
  output logic       irq_no,
  output logic       rst_no,
  output logic       wdt_flag_o
);
  import sup_pkg::*;

  localparam int unsigned WD_MAX  = WD_UNIT * 16;
  localparam int unsigned LD_MAX  = LD_UNIT * 4;
  localparam int unsigned RTO_MAX = RTO_UNIT * 8;
  localparam int unsigned T_MAX   = (WD_MAX > LD_MAX) ?
                                    ((WD_MAX > RTO_MAX) ? WD_MAX : RTO_MAX) :
                                    ((LD_MAX > RTO_MAX) ? LD_MAX : RTO_MAX);
  localparam int CNT_W = $clog2(T_MAX + 1);

  sup_cfg_t cfg;
  assign cfg = sup_cfg_t'(cfg_i);

  logic [CNT_W-1:0] wd_lim, ld_lim, rto_lim;
  assign wd_lim  = CNT_W'(wd_ticks(cfg.wd, WD_UNIT));
  assign ld_lim  = CNT_W'(ld_ticks(cfg.ld, LD_UNIT));
  assign rto_lim = CNT_W'(rto_ticks(cfg.rto, RTO_UNIT));

  logic kick_rise;
  logic wd_hit, ld_hit, rto_hit;
  logic rst_q, irq_q, flag_q;
  logic rst_end, irq_set;

  sup_kick_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .kick_i(kick_i),
    .rise_o(kick_rise)
  );

  // Watchdog and longdog are held cleared for the whole reset pulse
  sup_tmr #(.W(CNT_W)) u_wd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (kick_rise | rst_q),
    .tick_i (tick_i),
    .limit_i(wd_lim),
    .hit_o  (wd_hit)
  );

  sup_tmr #(.W(CNT_W)) u_ld (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (kick_rise | rst_q),
    .tick_i (tick_i),
    .limit_i(ld_lim),
    .hit_o  (ld_hit)
  );

  sup_tmr #(.W(CNT_W)) u_rto (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~rst_q | kick_rise),
    .tick_i (tick_i),
    .limit_i(rto_lim),
    .hit_o  (rto_hit)
  );

  assign rst_end = rst_q & (rto_hit | kick_rise);
  // longdog wins a same-tick tie; high kick level masks the interrupt
  assign irq_set = wd_hit & ~ld_hit & ~kick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q  <= 1'b0;
      irq_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (kick_rise || rto_hit) rst_q <= 1'b0;
      else if (ld_hit)          rst_q <= 1'b1;

      if (kick_rise || rst_end) irq_q <= 1'b0;
      else if (irq_set)         irq_q <= 1'b1;

      if (irq_set) flag_q <= 1'b1;
    end
  end

  assign irq_no     = ~irq_q;
  assign rst_no     = ~rst_q;
  assign wdt_flag_o = flag_q;

  p_kick_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_rise |=> (rst_no && irq_no));
  p_rst_end_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> irq_no);
  p_irq_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> !$past(kick_i));
  p_flag_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_flag_o |=> wdt_flag_o);
  p_rst_needs_ld_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_no) |-> ($past(cfg_i[4:3]) != 2'b00));

endmodule

// File: tb/sup_dual_dog_test.sv
module sup_dual_dog_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       kick = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic       irq_n, rst_out_n, flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sup_dual_dog uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .kick_i    (kick),
    .cfg_i     (cfg),
    .irq_no    (irq_n),
    .rst_no    (rst_out_n),
    .wdt_flag_o(flag)
  );

  typedef struct packed {
    logic [7:0]  cfg;
    logic [15:0] irq_at;
    logic [15:0] rst_at;
    logic [15:0] rst_w;
  } vec_t;

  // cfg: [6:5] rto, [4:3] ld, [2:0] wd; 0 means never
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h09, 16'd400,  16'd1600, 16'd25 },
    '{8'h32, 16'd800,  16'd3200, 16'd50 },
    '{8'h4B, 16'd0,    16'd1600, 16'd100},
    '{8'h68, 16'd0,    16'd1600, 16'd200},
    '{8'h0E, 16'd0,    16'd1600, 16'd25 },
    '{8'h01, 16'd400,  16'd0,    16'd0  },
    '{8'h0D, 16'd0,    16'd1600, 16'd25 },
    '{8'h89, 16'd400,  16'd1600, 16'd25 },
    '{8'h3C, 16'd3200, 16'd6400, 16'd50 },
    '{8'h07, 16'd0,    16'd0,    16'd0  }
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    kick = 1'b0;
    tick = 1'b1;
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic pulse_kick();
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
  endtask

  initial begin
    int irq_first, rst_first, rst_end;
    do_reset();
    cfg = 8'h09;
    @(negedge clk);
    chk("R12 irq_no", int'(irq_n), 1);
    chk("R12 rst_no", int'(rst_out_n), 1);
    chk("R12 flag", int'(flag), 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      do_reset();
      cfg = VECS[v].cfg;
      pulse_kick();
      irq_first = 0; rst_first = 0; rst_end = 0;
      for (int n = 1; n <= 7000; n++) begin
        @(negedge clk);
        if (!irq_n && irq_first == 0) irq_first = n;
        if (!rst_out_n && rst_first == 0) rst_first = n;
        if (rst_first != 0 && rst_out_n && rst_end == 0) begin
          rst_end = n;
          chk("R7 irq high at reset end", int'(irq_n), 1);
          break;
        end
      end
      chk("R2/R9/R11 irq tick", irq_first, int'(VECS[v].irq_at));
      chk("R4/R9 rst tick", rst_first, int'(VECS[v].rst_at));
      chk("R5 rst width", (rst_first != 0) ? rst_end - rst_first : 0, int'(VECS[v].rst_w));
      chk("R3 flag", int'(flag), (VECS[v].irq_at != 0) ? 1 : 0);
    end

    // R8 kick held high, then R6 early release
    do_reset();
    cfg = 8'h09;
    @(negedge clk) kick = 1'b1;
    @(negedge clk);
    irq_first = 0; rst_first = 0;
    for (int n = 1; n <= 1700; n++) begin
      @(negedge clk);
      if (!irq_n && irq_first == 0) irq_first = n;
      if (!rst_out_n && rst_first == 0) begin
        rst_first = n;
        break;
      end
    end
    chk("R8 irq masked", irq_first, 0);
    chk("R8 flag not set", int'(flag), 0);
    chk("R8 reset still active", rst_first, 1600);
    kick = 1'b0;
    @(negedge clk);
    chk("R6 reset held before kick", int'(rst_out_n), 0);
    kick = 1'b1;
    @(negedge clk);
    chk("R6 reset released by kick", int'(rst_out_n), 1);

    // R1 kick clears irq and restarts both timers
    do_reset();
    cfg = 8'h09;
    pulse_kick();
    repeat (400) @(negedge clk);
    chk("R2 irq at 400", int'(irq_n), 0);
    kick = 1'b1;
    @(negedge clk);
    chk("R1 irq released", int'(irq_n), 1);
    chk("R3 flag sticky", int'(flag), 1);
    kick = 1'b0;
    irq_first = 0; rst_first = 0;
    for (int n = 1; n <= 1600; n++) begin
      @(negedge clk);
      if (!irq_n && irq_first == 0) irq_first = n;
      if (!rst_out_n && rst_first == 0) rst_first = n;
    end
    chk("R1 wd restart", irq_first, 400);
    chk("R1 ld restart", rst_first, 1600);

    // R10 no ticks, no progress
    do_reset();
    cfg = 8'h09;
    tick = 1'b0;
    pulse_kick();
    repeat (2000) @(negedge clk);
    chk("R10 irq idle", int'(irq_n), 1);
    chk("R10 rst idle", int'(rst_out_n), 1);
    tick = 1'b1;
    irq_first = 0;
    for (int n = 1; n <= 500; n++) begin
      @(negedge clk);
      if (!irq_n && irq_first == 0) irq_first = n;
    end
    chk("R10 irq after ticks resume", irq_first, 400);

    // R1 regular service keeps both quiet
    do_reset();
    cfg = 8'h09;
    irq_first = 0; rst_first = 0;
    for (int k = 0; k < 10; k++) begin
      pulse_kick();
      for (int n = 0; n < 300; n++) begin
        @(negedge clk);
        if (!irq_n) irq_first = 1;
        if (!rst_out_n) rst_first = 1;
      end
    end
    chk("R1 serviced irq", irq_first, 0);
    chk("R1 serviced rst", rst_first, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule